// File: doc/BRIEF.md
# Receive Character Queue with Idle Timeout

This block sits between a serial receive deserializer and the host-facing register logic of an asynchronous serial port. Each completed character comes in with a one-cycle strobe, an 8-bit data byte and three error flags (parity error, framing error, break seen). The block queues up to sixteen characters, each one stored together with its own flags. It shows the oldest character and its flags to the host until the host reads it.

Two interrupt causes come out of the queue. The data-available cause is active while the fill level is at or above a threshold chosen by a 2-bit field. The character-timeout cause fires when characters have been waiting with no new arrival and no host read for a number of bit periods set by the word length. A bit-period tick from the baud logic is the time base. An active-low ready strobe for DMA-style servicing, a data-ready flag and a sticky error summary for the line-status view are also provided. A clear input flushes the queue at any time.

Top module: `rx_fifo_timeout`

## Requirements
- R1: After synchronous reset, level = 0, data_ready = 0, fifo_err = 0, irq = 0, rxrdy_n = 1, and irq_status = 4'b0001 (the "nothing pending" code).
- R2: Characters leave in arrival order. rd_data, rd_perr, rd_ferr and rd_brk show the oldest stored entry, and a cycle with rd_en high removes that entry.
- R3: The queue holds 16 entries. A character that arrives while 16 are stored, with no read in the same cycle, is discarded, and level and the stored contents stay unchanged.
- R4: rd_en while the queue is empty has no effect: level stays 0 and data_ready stays 0.
- R5: trig_sel encodes the threshold as 00 = 1, 01 = 4, 10 = 8 and 11 = 14 characters. While level is at or above the threshold, irq_status = 4'b0100 and irq = 1.
- R6: With word_sel = w (word length 5 + w bits), after 4*(5+w)+12 = 32+4w bit_tick pulses with no arrival and no read, while level is non-zero and below the threshold, irq_status = 4'b1100 and irq = 1. One tick fewer leaves irq_status = 4'b0001.
- R7: Every accepted arrival and every read restarts the timeout count. While the queue is empty, no timeout is ever signalled, whatever the number of ticks.
- R8: When the threshold is met and a timeout has also elapsed, irq_status shows the data-available code 4'b0100.
- R9: fifo_err goes to 1 when an accepted character carries any of its three flags. It stays 1 across later clean arrivals and drops to 0 on a read. An erroneous arrival in the same cycle as a read leaves it at 1.
- R10: rxrdy_n goes low when the threshold is reached or a timeout occurs. It stays low while any character remains, even below the threshold, and returns high once the queue is empty.
- R11: fifo_clr empties the queue, clears fifo_err and any pending timeout, and discards a character arriving in the same cycle.
- R12: With 16 stored, an arrival and a read in the same cycle are both carried out: level stays 16 and the new character becomes the last entry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| char_valid | input | 1 | One-cycle strobe: a received character is presented |
| char_data | input | 8 | Received data byte |
| char_perr | input | 1 | Parity error flag of the presented character |
| char_ferr | input | 1 | Framing error flag of the presented character |
| char_brk | input | 1 | Break flag of the presented character |
| bit_tick | input | 1 | One pulse per serial bit period |
| word_sel | input | 2 | Word length select, length = 5 + word_sel bits |
| trig_sel | input | 2 | Threshold select (1, 4, 8, 14) |
| fifo_clr | input | 1 | One-cycle flush of the queue |
| rd_en | input | 1 | Host read of the oldest character |
| rd_data | output | 8 | Data byte of the oldest character |
| rd_perr | output | 1 | Parity flag of the oldest character |
| rd_ferr | output | 1 | Framing flag of the oldest character |
| rd_brk | output | 1 | Break flag of the oldest character |
| level | output | 5 | Number of stored characters |
| data_ready | output | 1 | At least one character stored |
| fifo_err | output | 1 | Sticky error summary |
| irq | output | 1 | Interrupt request |
| irq_status | output | 4 | Interrupt code: 0001 none, 0100 data available, 1100 timeout |
| rxrdy_n | output | 1 | Active-low receive ready |

## Verification
For every threshold code the queue is filled one character at a time up to and past 16 entries and then drained. This separates the four threshold decodes and checks ordering, flag storage and overflow discard in a single pass. For every word length the tick count is swept to one short of the limit and then to the limit itself, so an off-by-one in the timeout length shows up. The same count is repeated after an arrival and after a read to show that both restart it. Separate patterns set a threshold hit against a timeout, an erroneous arrival against a clean one and against a same-cycle read, and a flush against a same-cycle arrival.

// File: rtl/rxf_pkg.sv
package rxf_pkg;

  typedef struct packed {
    logic       brk;
    logic       ferr;
    logic       perr;
    logic [7:0] data;
  } rx_entry_t;

  localparam logic [3:0] ISR_NONE = 4'b0001;
  localparam logic [3:0] ISR_RDA  = 4'b0100;
  localparam logic [3:0] ISR_CTO  = 4'b1100;

  localparam int TMO_W = 6;

  function automatic logic [4:0] trig_level(input logic [1:0] sel);
    case (sel)
      2'b00:   return 5'd1;
      2'b01:   return 5'd4;
      2'b10:   return 5'd8;
      default: return 5'd14;
    endcase
  endfunction

  // four bit periods per data bit plus twelve, data bits = 5 + sel
  function automatic logic [TMO_W-1:0] tmo_limit(input logic [1:0] sel);
    return TMO_W'(32) + TMO_W'({sel, 2'b00});
  endfunction

endpackage

// File: rtl/rxf_store.sv
module rxf_store
  import rxf_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int AW    = $clog2(DEPTH),
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic      clk,
  input  logic      rst,
  input  logic      clr,
  input  logic      push,
  input  rx_entry_t wr_entry,
  input  logic      pop,
  output rx_entry_t head,
  output logic [CW-1:0] count,
  output logic      push_ok,
  output logic      pop_ok
);

  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  rx_entry_t mem [DEPTH];
  logic [AW-1:0] wr_ptr;
  logic [AW-1:0] rd_ptr;

  assign pop_ok  = pop && (count != '0) && !clr;
  assign push_ok = push && !clr && ((count != FULL) || pop_ok);

  // storage without reset so a RAM primitive can be inferred
  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= wr_entry;
  end

  assign head = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_ok) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
      if (pop_ok)  rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
      case ({push_ok, pop_ok})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

endmodule

// File: rtl/rxf_timeout.sv
module rxf_timeout
  import rxf_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       restart,
  input  logic       nonempty,
  input  logic       bit_tick,
  input  logic [1:0] word_sel,
  output logic       expired
);

  logic [TMO_W-1:0] cnt;
  logic [TMO_W-1:0] last;

  assign last = tmo_limit(word_sel) - 1'b1;

  always_ff @(posedge clk) begin
    if (rst || restart || !nonempty) begin
      cnt     <= '0;
      expired <= 1'b0;
    end else if (bit_tick && !expired) begin
      if (cnt == last) begin
        expired <= 1'b1;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end

endmodule

// File: rtl/rxf_status.sv
module rxf_status
  import rxf_pkg::*;
#(
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic [CW-1:0] level,
  input  logic [1:0]    trig_sel,
  input  logic          expired,
  input  logic          push_err,
  input  logic          pop_ok,
  output logic [3:0]    irq_status,
  output logic          irq,
  output logic          rxrdy_n,
  output logic          data_ready,
  output logic          fifo_err
);

  logic trig_hit;
  logic rdy_act;

  assign trig_hit = (level >= CW'(trig_level(trig_sel)));
  assign rxrdy_n  = ~rdy_act;

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_status <= ISR_NONE;
      irq        <= 1'b0;
      rdy_act    <= 1'b0;
      data_ready <= 1'b0;
    end else begin
      data_ready <= (level != '0);
      if (trig_hit) begin
        irq_status <= ISR_RDA;
        irq        <= 1'b1;
      end else if (expired) begin
        irq_status <= ISR_CTO;
        irq        <= 1'b1;
      end else begin
        irq_status <= ISR_NONE;
        irq        <= 1'b0;
      end
      if (level == '0)             rdy_act <= 1'b0;
      else if (trig_hit || expired) rdy_act <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || clr)    fifo_err <= 1'b0;
    else if (push_err) fifo_err <= 1'b1;
    else if (pop_ok)   fifo_err <= 1'b0;
  end

endmodule

// File: rtl/rx_fifo_timeout.sv
module rx_fifo_timeout
  import rxf_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          char_valid,
  input  logic [7:0]    char_data,
  input  logic          char_perr,
  input  logic          char_ferr,
  input  logic          char_brk,
  input  logic          bit_tick,
  input  logic [1:0]    word_sel,
  input  logic [1:0]    trig_sel,
  input  logic          fifo_clr,
  input  logic          rd_en,
  output logic [7:0]    rd_data,
  output logic          rd_perr,
  output logic          rd_ferr,
  output logic          rd_brk,
  output logic [CW-1:0] level,
  output logic          data_ready,
  output logic          fifo_err,
  output logic          irq,
  output logic [3:0]    irq_status,
  output logic          rxrdy_n
);

  localparam int AW = $clog2(DEPTH);

  rx_entry_t wr_entry;
  rx_entry_t head;
  logic      push_ok;
  logic      pop_ok;
  logic      expired;
  logic      push_err;

  assign wr_entry = '{brk: char_brk, ferr: char_ferr, perr: char_perr, data: char_data};
  assign push_err = push_ok && (char_perr || char_ferr || char_brk);

  rxf_store #(.DEPTH(DEPTH), .AW(AW), .CW(CW)) u_store (
    .clk      (clk),
    .rst      (rst),
    .clr      (fifo_clr),
    .push     (char_valid),
    .wr_entry (wr_entry),
    .pop      (rd_en),
    .head     (head),
    .count    (level),
    .push_ok  (push_ok),
    .pop_ok   (pop_ok)
  );

  rxf_timeout u_tmo (
    .clk      (clk),
    .rst      (rst),
    .restart  (push_ok || pop_ok || fifo_clr),
    .nonempty (level != '0),
    .bit_tick (bit_tick),
    .word_sel (word_sel),
    .expired  (expired)
  );

  rxf_status #(.CW(CW)) u_status (
    .clk        (clk),
    .rst        (rst),
    .clr        (fifo_clr),
    .level      (level),
    .trig_sel   (trig_sel),
    .expired    (expired),
    .push_err   (push_err),
    .pop_ok     (pop_ok),
    .irq_status (irq_status),
    .irq        (irq),
    .rxrdy_n    (rxrdy_n),
    .data_ready (data_ready),
    .fifo_err   (fifo_err)
  );

  assign rd_data = head.data;
  assign rd_perr = head.perr;
  assign rd_ferr = head.ferr;
  assign rd_brk  = head.brk;

endmodule

// File: rtl/rxf_checker.sv
module rxf_checker #(
  parameter int DEPTH = 16,
  parameter int CW    = 5
) (
  input logic          clk,
  input logic          rst,
  input logic          char_valid,
  input logic          rd_en,
  input logic          fifo_clr,
  input logic [CW-1:0] level,
  input logic          fifo_err,
  input logic [3:0]    irq_status,
  input logic          rxrdy_n
);

  // R3
  level_bound_chk: assert property (@(posedge clk) disable iff (rst)
    level <= CW'(DEPTH));

  // R3
  full_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (level == CW'(DEPTH) && char_valid && !rd_en && !fifo_clr) |=> (level == CW'(DEPTH)));

  // R4
  empty_read_chk: assert property (@(posedge clk) disable iff (rst)
    (level == '0 && rd_en && !char_valid) |=> (level == '0));

  // R7
  empty_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (level == '0) |=> (irq_status == 4'b0001));

  // R10
  empty_ready_chk: assert property (@(posedge clk) disable iff (rst)
    (level == '0) |=> rxrdy_n);

  // R11
  flush_chk: assert property (@(posedge clk) disable iff (rst)
    fifo_clr |=> (level == '0 && !fifo_err));

  // R5
  code_legal_chk: assert property (@(posedge clk) disable iff (rst)
    (irq_status == 4'b0001 || irq_status == 4'b0100 || irq_status == 4'b1100));

endmodule

bind rx_fifo_timeout rxf_checker #(.DEPTH(DEPTH), .CW(CW)) u_rxf_checker (
  .clk        (clk),
  .rst        (rst),
  .char_valid (char_valid),
  .rd_en      (rd_en),
  .fifo_clr   (fifo_clr),
  .level      (level),
  .fifo_err   (fifo_err),
  .irq_status (irq_status),
  .rxrdy_n    (rxrdy_n)
);

// File: tb/test_rx_fifo_timeout.sv
`timescale 1ns/1ps
module test_rx_fifo_timeout;

  logic       clk = 1'b0;
  logic       rst;
  logic       char_valid, char_perr, char_ferr, char_brk;
  logic [7:0] char_data;
  logic       bit_tick, fifo_clr, rd_en;
  logic [1:0] word_sel, trig_sel;
  logic [7:0] rd_data;
  logic       rd_perr, rd_ferr, rd_brk;
  logic [4:0] level;
  logic       data_ready, fifo_err, irq, rxrdy_n;
  logic [3:0] irq_status;

  int n_run  = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  rx_fifo_timeout i_rx_fifo_timeout (
    .clk(clk), .rst(rst), .char_valid(char_valid), .char_data(char_data),
    .char_perr(char_perr), .char_ferr(char_ferr), .char_brk(char_brk),
    .bit_tick(bit_tick), .word_sel(word_sel), .trig_sel(trig_sel),
    .fifo_clr(fifo_clr), .rd_en(rd_en), .rd_data(rd_data), .rd_perr(rd_perr),
    .rd_ferr(rd_ferr), .rd_brk(rd_brk), .level(level), .data_ready(data_ready),
    .fifo_err(fifo_err), .irq(irq), .irq_status(irq_status), .rxrdy_n(rxrdy_n)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic op(input logic cv, input logic [7:0] d, input logic p, input logic f,
                    input logic b, input logic rd, input logic cl);
    @(negedge clk);
    char_valid = cv; char_data = d; char_perr = p; char_ferr = f; char_brk = b;
    rd_en = rd; fifo_clr = cl;
    @(negedge clk);
    char_valid = 1'b0; rd_en = 1'b0; fifo_clr = 1'b0;
    idle(2);
  endtask

  task automatic push(input logic [7:0] d, input logic p, input logic f, input logic b);
    op(1'b1, d, p, f, b, 1'b0, 1'b0);
  endtask

  task automatic pop();
    op(1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
  endtask

  task automatic flush();
    op(1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
  endtask

  task automatic ticks(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); bit_tick = 1'b1;
      @(negedge clk); bit_tick = 1'b0;
    end
    idle(2);
  endtask

  function automatic int thr(input int t);
    case (t)
      0: return 1;
      1: return 4;
      2: return 8;
      default: return 14;
    endcase
  endfunction

  initial begin
    #2_000_000;
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    rst = 1'b1; char_valid = 0; char_data = 0; char_perr = 0; char_ferr = 0; char_brk = 0;
    bit_tick = 0; fifo_clr = 0; rd_en = 0; word_sel = 0; trig_sel = 0;
    idle(3);
    rst = 1'b0;
    idle(2);
    // R1 reset state
    chk("R1 level", level, 0);
    chk("R1 data_ready", data_ready, 0);
    chk("R1 fifo_err", fifo_err, 0);
    chk("R1 irq", irq, 0);
    chk("R1 rxrdy_n", rxrdy_n, 1);
    chk("R1 irq_status", irq_status, 4'b0001);

    // R4 read on empty
    pop();
    chk("R4 level", level, 0);
    chk("R4 data_ready", data_ready, 0);

    // R2 R3 R5 R10 threshold sweep, fill past full, drain
    for (int t = 0; t < 4; t++) begin
      trig_sel = 2'(t);
      for (int i = 0; i < 16; i++) begin
        push(8'(t * 16 + i), i[0], i[1], i[2]);
        chk("R5 level", level, i + 1);
        chk("R5 irq_status", irq_status, (i + 1 >= thr(t)) ? 4'b0100 : 4'b0001);
        chk("R5 irq", irq, (i + 1 >= thr(t)) ? 1 : 0);
        chk("R10 rxrdy_n fill", rxrdy_n, (i + 1 >= thr(t)) ? 0 : 1);
      end
      push(8'hEE, 1'b0, 1'b0, 1'b0);
      chk("R3 level full", level, 16);
      chk("R3 head kept", rd_data, t * 16);
      for (int i = 0; i < 16; i++) begin
        chk("R2 data", rd_data, t * 16 + i);
        chk("R2 flags", {rd_brk, rd_ferr, rd_perr}, i % 8);
        pop();
        chk("R10 rxrdy_n drain", rxrdy_n, (i == 15) ? 1 : 0);
      end
      chk("R2 empty", data_ready, 0);
      chk("R5 irq_status empty", irq_status, 4'b0001);
    end

    // R6 R7 timeout per word length, threshold 14 kept out of reach
    trig_sel = 2'b11;
    for (int w = 0; w < 4; w++) begin
      word_sel = 2'(w);
      push(8'(8'hA0 + w), 1'b0, 1'b0, 1'b0);
      ticks(31 + 4 * w);
      chk("R6 one short", irq_status, 4'b0001);
      chk("R10 rxrdy_n before timeout", rxrdy_n, 1);
      ticks(1);
      chk("R6 timeout code", irq_status, 4'b1100);
      chk("R6 irq", irq, 1);
      chk("R10 rxrdy_n timeout", rxrdy_n, 0);
      push(8'h5A, 1'b0, 1'b0, 1'b0);
      chk("R7 arrival clears", irq_status, 4'b0001);
      ticks(31 + 4 * w);
      chk("R7 arrival restarts", irq_status, 4'b0001);
      pop();
      ticks(31 + 4 * w);
      chk("R7 read restarts", irq_status, 4'b0001);
      chk("R10 rxrdy_n held", rxrdy_n, 0);
      ticks(1);
      chk("R7 timeout after read", irq_status, 4'b1100);
      pop();
      chk("R7 empty after reads", irq_status, 4'b0001);
      chk("R10 rxrdy_n empty", rxrdy_n, 1);
    end
    ticks(60);
    chk("R7 empty no timeout", irq_status, 4'b0001);

    // R8 threshold hit wins over timeout
    trig_sel = 2'b00; word_sel = 2'b00;
    push(8'h11, 1'b0, 1'b0, 1'b0);
    ticks(40);
    chk("R8 priority", irq_status, 4'b0100);
    pop();

    // R9 sticky error summary
    trig_sel = 2'b11;
    push(8'h01, 1'b0, 1'b0, 1'b0);
    chk("R9 clean", fifo_err, 0);
    push(8'h02, 1'b1, 1'b0, 1'b0);
    chk("R9 parity sets", fifo_err, 1);
    push(8'h03, 1'b0, 1'b0, 1'b0);
    chk("R9 held", fifo_err, 1);
    pop();
    chk("R9 read clears", fifo_err, 0);
    push(8'h04, 1'b0, 1'b1, 1'b0);
    chk("R9 framing sets", fifo_err, 1);
    pop();
    push(8'h05, 1'b0, 1'b0, 1'b1);
    chk("R9 break sets", fifo_err, 1);
    op(1'b1, 8'h06, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0);
    chk("R9 same-cycle error wins", fifo_err, 1);

    // R11 flush with same-cycle arrival
    op(1'b1, 8'h77, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
    chk("R11 level", level, 0);
    chk("R11 fifo_err", fifo_err, 0);
    chk("R11 data_ready", data_ready, 0);
    chk("R11 irq_status", irq_status, 4'b0001);

    // R12 simultaneous arrival and read when full
    for (int i = 0; i < 16; i++) push(8'(8'hC0 + i), 1'b0, 1'b0, 1'b0);
    op(1'b1, 8'h55, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
    chk("R12 level", level, 16);
    chk("R12 new head", rd_data, 8'hC1);
    for (int i = 0; i < 15; i++) pop();
    chk("R12 last entry", rd_data, 8'h55);
    flush();
    chk("R11 flush full", level, 0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule